// File: doc/BRIEF.md
# I2C Control Register Sequencer

This block is the control register of an I2C serial interface together with the small sequencer that its command bits drive. A processor writes it over a simple synchronous register port and reads it back. The persistent bits are passed as configuration levels to the bit-level bus engine: enable, stop-interrupt enable, wait timing, acknowledge enable, and the start and stop requests. Two command bits are strobes. They act once and never read back as set.

The exit command aborts the transfer in progress. It pulses a clear to the engine's status flags and drops any pending start or stop request. It then parks the interface in a standby state in which SCL and SDA are both released. Standby ends when a stop condition is seen. It also ends when a start condition is seen and is then followed by an address match or by reception of an extension code. The wait-cancel command releases a pending wait. If that wait sits at the ninth clock while the interface transmits, it also releases SDA and clears the engine's transmit-mode flag. While the enable bit is 0, internal operation stops and the engine's status state is held in reset.

Top module: `i2c_ctl_seq`

## Requirements
- R1: After the asynchronous active-low reset, the register reads 0x00, standby and both line releases are low, every command pulse is low, and the status reset output is high.
- R2: The bit positions are: 7 enable, 6 exit command, 5 wait-cancel command, 4 stop-interrupt enable, 3 wait timing, 2 acknowledge enable, 1 start request, 0 stop request. Writes to bits 7 and 4..0 read back as written. Bits 6 and 5 always read 0.
- R3: A command takes effect only when the enable bit is already 1 and the same write also carries enable = 1. Otherwise bits 6 and 5 are ignored: no pulse, no standby, and the start and stop request bits are stored as written.
- R4: An accepted exit command makes the flag-clear output high for exactly the one cycle after the write. Standby asserts in that same cycle. The start and stop request bits read 0 afterwards, whatever value the write carried.
- R5: While standby is high, both the SCL release and the SDA release outputs are high.
- R6: In standby, a stop-detected pulse drops standby in the next cycle.
- R7: In standby, an address-match or extension-code pulse ends standby in the next cycle only after a start-detected pulse has been seen during standby. Without that start it is ignored.
- R8: An accepted wait-cancel command makes the wait-cancel output high for exactly the one cycle after the write. The transmit-clear output pulses in the same cycle only if the wait-active and transmit-mode inputs were both high at the write.
- R9: When exit and wait-cancel are accepted in the same write, only the exit takes effect.
- R10: A write with enable = 0 clears standby in the next cycle and holds the status reset output high for as long as enable stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data (command bits read 0) |
| evtStart | input | 1 | Start condition detected (one-cycle pulse) |
| evtStop | input | 1 | Stop condition detected (one-cycle pulse) |
| evtAddrMatch | input | 1 | Own address matched (one-cycle pulse) |
| evtExtCode | input | 1 | Extension code received (one-cycle pulse) |
| waitActive | input | 1 | Engine is holding a ninth-clock wait |
| txMode | input | 1 | Engine is in transmit mode |
| cfgStopIrqEn | output | 1 | Stop-interrupt enable level |
| cfgWaitTiming | output | 1 | Wait timing select level |
| cfgAckEn | output | 1 | Acknowledge enable level |
| cfgStartReq | output | 1 | Start condition request level |
| cfgStopReq | output | 1 | Stop condition request level |
| statusRst | output | 1 | Holds engine status, start-clear, busy and line-level flags in reset |
| flagClr | output | 1 | Pulse clearing master, extension, address-match, transmit, ack-detected and start-detected flags |
| waitCancel | output | 1 | Pulse releasing a pending wait |
| txClear | output | 1 | Pulse releasing SDA and clearing transmit mode at a ninth-clock transmit wait |
| sclRelease | output | 1 | SCL driver forced to high impedance |
| sdaRelease | output | 1 | SDA driver forced to high impedance |
| standby | output | 1 | Interface parked after an exit command |

## Verification
The hardest state to reach is the second half of the standby exit path. In that state a start has already been seen during standby, and standby now ends only on an address match or an extension code. The stimulus first issues an accepted exit command. It then sends a lone address-match pulse and checks that nothing happens, and only then sends a start followed by the match (or by an extension code). The disabled-command case is reached by writing a command together with enable = 1 while the stored enable is still 0, which separates the stored enable from the written one.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_EN   = 7;
  localparam int BIT_EXIT = 6;
  localparam int BIT_WREL = 5;
  localparam int BIT_SPIE = 4;
  localparam int BIT_WTIM = 3;
  localparam int BIT_ACKE = 2;
  localparam int BIT_STT  = 1;
  localparam int BIT_SPT  = 0;

  // bits that persist in storage; command strobes are never stored
  localparam logic [REG_W-1:0] KEEP_MASK =
    ~((REG_W'(1) << BIT_EXIT) | (REG_W'(1) << BIT_WREL));
  localparam logic [REG_W-1:0] TRIG_MASK =
    (REG_W'(1) << BIT_STT) | (REG_W'(1) << BIT_SPT);

  typedef struct packed {
    logic exitGo;
    logic waitGo;
    logic txRel;
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    SB_IDLE       = 2'd0,
    SB_WAIT_START = 2'd1,
    SB_WAIT_ADDR  = 2'd2
  } sbState_t;
endpackage

// File: rtl/i2c_ctl_ctrl.sv
module i2c_ctl_ctrl
  import i2c_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] cmdBits,   // {enable, exit, wait-cancel} of the write
  input  logic       enQ,
  input  logic       evtStart,
  input  logic       evtStop,
  input  logic       evtAddrMatch,
  input  logic       evtExtCode,
  input  logic       waitActive,
  input  logic       txMode,
  output ctlStrobe_t strobe,
  output logic       standby
);
  logic     wrEnBit, wrExit, wrWrel, cmdOk, disableWr;
  sbState_t state, stateNxt;

  assign wrEnBit = cmdBits[2];
  assign wrExit  = cmdBits[1];
  assign wrWrel  = cmdBits[0];

  // commands honoured only with the interface already enabled and kept enabled
  assign cmdOk     = wrEn && enQ && wrEnBit;
  assign disableWr = wrEn && !wrEnBit;

  always_comb begin
    strobe.exitGo = cmdOk && wrExit;
    strobe.waitGo = cmdOk && wrWrel && !wrExit;   // exit wins
    strobe.txRel  = strobe.waitGo && waitActive && txMode;
  end

  always_comb begin
    stateNxt = state;
    if (disableWr || !enQ) begin
      stateNxt = SB_IDLE;
    end else if (strobe.exitGo) begin
      stateNxt = SB_WAIT_START;
    end else begin
      unique case (state)
        SB_WAIT_START: begin
          if (evtStop)       stateNxt = SB_IDLE;
          else if (evtStart) stateNxt = SB_WAIT_ADDR;
        end
        SB_WAIT_ADDR: begin
          if (evtStop || evtAddrMatch || evtExtCode) stateNxt = SB_IDLE;
        end
        default: stateNxt = SB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SB_IDLE;
    else       state <= stateNxt;
  end

  assign standby = (state != SB_IDLE);
endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
  import i2c_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  ctlStrobe_t       strobe,
  input  logic             standby,
  output logic [REG_W-1:0] rdData,
  output logic             enQ,
  output logic             cfgStopIrqEn,
  output logic             cfgWaitTiming,
  output logic             cfgAckEn,
  output logic             cfgStartReq,
  output logic             cfgStopReq,
  output logic             statusRst,
  output logic             flagClr,
  output logic             waitCancel,
  output logic             txClear,
  output logic             sclRelease,
  output logic             sdaRelease
);
  logic [REG_W-1:0] cfgQ, cfgNxt;
  logic             exitQ, waitQ, txRelQ;

  always_comb begin
    cfgNxt = cfgQ;
    if (wrEn) begin
      cfgNxt = wrData & KEEP_MASK;
      if (strobe.exitGo) cfgNxt = cfgNxt & ~TRIG_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ   <= '0;
      exitQ  <= 1'b0;
      waitQ  <= 1'b0;
      txRelQ <= 1'b0;
    end else begin
      cfgQ   <= cfgNxt;
      exitQ  <= strobe.exitGo;
      waitQ  <= strobe.waitGo;
      txRelQ <= strobe.txRel;
    end
  end

  assign rdData        = cfgQ & KEEP_MASK;
  assign enQ           = cfgQ[BIT_EN];
  assign cfgStopIrqEn  = cfgQ[BIT_SPIE];
  assign cfgWaitTiming = cfgQ[BIT_WTIM];
  assign cfgAckEn      = cfgQ[BIT_ACKE];
  assign cfgStartReq   = cfgQ[BIT_STT];
  assign cfgStopReq    = cfgQ[BIT_SPT];
  assign statusRst     = !cfgQ[BIT_EN];
  assign flagClr       = exitQ;
  assign waitCancel    = waitQ;
  assign txClear       = txRelQ;
  assign sclRelease    = standby;
  assign sdaRelease    = standby;
endmodule

// File: rtl/i2c_ctl_seq.sv
module i2c_ctl_seq
  import i2c_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             evtStart,
  input  logic             evtStop,
  input  logic             evtAddrMatch,
  input  logic             evtExtCode,
  input  logic             waitActive,
  input  logic             txMode,
  output logic             cfgStopIrqEn,
  output logic             cfgWaitTiming,
  output logic             cfgAckEn,
  output logic             cfgStartReq,
  output logic             cfgStopReq,
  output logic             statusRst,
  output logic             flagClr,
  output logic             waitCancel,
  output logic             txClear,
  output logic             sclRelease,
  output logic             sdaRelease,
  output logic             standby
);
  ctlStrobe_t strobe;
  logic       enQ;

  i2c_ctl_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .cmdBits      ({wrData[BIT_EN], wrData[BIT_EXIT], wrData[BIT_WREL]}),
    .enQ          (enQ),
    .evtStart     (evtStart),
    .evtStop      (evtStop),
    .evtAddrMatch (evtAddrMatch),
    .evtExtCode   (evtExtCode),
    .waitActive   (waitActive),
    .txMode       (txMode),
    .strobe       (strobe),
    .standby      (standby)
  );

  i2c_ctl_regs regs_i (
    .clk           (clk),
    .rstN          (rstN),
    .wrEn          (wrEn),
    .wrData        (wrData),
    .strobe        (strobe),
    .standby       (standby),
    .rdData        (rdData),
    .enQ           (enQ),
    .cfgStopIrqEn  (cfgStopIrqEn),
    .cfgWaitTiming (cfgWaitTiming),
    .cfgAckEn      (cfgAckEn),
    .cfgStartReq   (cfgStartReq),
    .cfgStopReq    (cfgStopReq),
    .statusRst     (statusRst),
    .flagClr       (flagClr),
    .waitCancel    (waitCancel),
    .txClear       (txClear),
    .sclRelease    (sclRelease),
    .sdaRelease    (sdaRelease)
  );
endmodule

// File: rtl/i2c_ctl_seq_chk.sv
module i2c_ctl_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       evtStop,
  input logic       statusRst,
  input logic       flagClr,
  input logic       waitCancel,
  input logic       txClear,
  input logic       sclRelease,
  input logic       sdaRelease,
  input logic       standby
);
  a_r2_cmd_bits_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[6:5] == 2'b00);

  a_r3_ignored_when_off: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !rdData[7] |=> !flagClr && !waitCancel);

  a_r4_exit_enters_standby: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && rdData[7] && wrData[7] && wrData[6] |=> flagClr && standby && rdData[1:0] == 2'b00);

  a_r4_flag_clear_single: assert property (@(posedge clk) disable iff (!rstN)
    flagClr |=> !flagClr || $past(wrEn));

  a_r5_lines_released: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> sclRelease && sdaRelease);

  a_r6_stop_ends_standby: assert property (@(posedge clk) disable iff (!rstN)
    standby && evtStop && !wrEn |=> !standby);

  a_r8_tx_clear_with_cancel: assert property (@(posedge clk) disable iff (!rstN)
    txClear |-> waitCancel);

  a_r9_exit_priority: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && rdData[7] && wrData[7:5] == 3'b111 |=> flagClr && !waitCancel);

  a_r10_disabled_state: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[7] |-> statusRst && !standby);
endmodule

bind i2c_ctl_seq i2c_ctl_seq_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .rdData     (rdData),
  .evtStop    (evtStop),
  .statusRst  (statusRst),
  .flagClr    (flagClr),
  .waitCancel (waitCancel),
  .txClear    (txClear),
  .sclRelease (sclRelease),
  .sdaRelease (sdaRelease),
  .standby    (standby)
);

// File: tb/i2c_ctl_seq_tb.sv
`timescale 1ns/1ps
module i2c_ctl_seq_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       evtStart = 1'b0, evtStop = 1'b0, evtAddrMatch = 1'b0, evtExtCode = 1'b0;
  logic       waitActive = 1'b0, txMode = 1'b0;
  logic [7:0] rdData;
  logic       cfgStopIrqEn, cfgWaitTiming, cfgAckEn, cfgStartReq, cfgStopReq;
  logic       statusRst, flagClr, waitCancel, txClear, sclRelease, sdaRelease, standby;

  always #10 clk = ~clk;   // 50 MHz

  i2c_ctl_seq dut_i (.*);

  typedef struct {
    int          cyc;
    logic [14:0] exp;
    string       req;
  } sbItem_t;

  sbItem_t q[$];
  int      cyc = 0;
  int      nChk = 0;
  int      nErr = 0;
  bit      done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [14:0] mk(logic [7:0] rd, logic ex, logic wc, logic tx,
                                     logic sb, logic st);
    return {rd, ex, wc, tx, sb, sb, sb, st};
  endfunction

  // monitor: compare the observed outputs with queued expectations
  always begin
    @(negedge clk);
    #1;
    while (q.size() > 0 && q[0].cyc == cyc) begin
      sbItem_t it;
      logic [14:0] obs;
      it  = q.pop_front();
      obs = {rdData, flagClr, waitCancel, txClear, standby, sclRelease, sdaRelease, statusRst};
      nChk++;
      if (obs !== it.exp) begin
        nErr++;
        $display("FAIL %s: got %h expected %h", it.req, obs, it.exp);
      end
    end
  end

  // driver: apply one cycle of stimulus and queue the result for the next cycle
  task automatic step(input logic we, input logic [7:0] d, input logic [3:0] ev,
                      input logic wa, input logic tm, input logic [14:0] exp,
                      input string req);
    @(negedge clk);
    wrEn = we; wrData = d;
    {evtStart, evtStop, evtAddrMatch, evtExtCode} = ev;
    waitActive = wa; txMode = tm;
    q.push_back('{cyc + 1, exp, req});
  endtask

  localparam logic [3:0] EV_NONE = 4'b0000, EV_START = 4'b1000, EV_STOP = 4'b0100,
                         EV_ADDR = 4'b0010, EV_EXT = 4'b0001;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    step(0, 8'h00, EV_NONE, 0, 0, mk(8'h00, 0, 0, 0, 0, 1), "R1 reset state");
    step(1, 8'h40, EV_NONE, 0, 0, mk(8'h00, 0, 0, 0, 0, 1), "R3 exit while disabled");
    step(1, 8'h20, EV_NONE, 0, 0, mk(8'h00, 0, 0, 0, 0, 1), "R3 wait-cancel while disabled");
    step(1, 8'hC0, EV_NONE, 0, 0, mk(8'h80, 0, 0, 0, 0, 0), "R3 exit with enabling write");
    step(1, 8'h9D, EV_NONE, 0, 0, mk(8'h9D, 0, 0, 0, 0, 0), "R2 readback of persistent bits");
    step(1, 8'hFF, EV_NONE, 0, 0, mk(8'h9C, 1, 0, 0, 1, 0), "R9 exit over wait-cancel, R5 release");
    step(0, 8'h00, EV_NONE, 0, 0, mk(8'h9C, 0, 0, 0, 1, 0), "R4 flag clear lasts one cycle");
    step(0, 8'h00, EV_ADDR, 0, 0, mk(8'h9C, 0, 0, 0, 1, 0), "R7 match without start ignored");
    step(0, 8'h00, EV_START, 0, 0, mk(8'h9C, 0, 0, 0, 1, 0), "R7 start keeps standby");
    step(0, 8'h00, EV_ADDR, 0, 0, mk(8'h9C, 0, 0, 0, 0, 0), "R7 match after start ends standby");
    step(1, 8'hC3, EV_NONE, 0, 0, mk(8'h80, 1, 0, 0, 1, 0), "R4 exit clears start/stop requests");
    step(0, 8'h00, EV_STOP, 0, 0, mk(8'h80, 0, 0, 0, 0, 0), "R6 stop ends standby");
    step(1, 8'hC0, EV_NONE, 0, 0, mk(8'h80, 1, 0, 0, 1, 0), "R4 exit again");
    step(0, 8'h00, EV_START, 0, 0, mk(8'h80, 0, 0, 0, 1, 0), "R7 start in standby");
    step(0, 8'h00, EV_EXT, 0, 0, mk(8'h80, 0, 0, 0, 0, 0), "R7 extension code ends standby");
    step(1, 8'hA0, EV_NONE, 1, 1, mk(8'h80, 0, 1, 1, 0, 0), "R8 cancel at transmit wait");
    step(0, 8'h00, EV_NONE, 0, 0, mk(8'h80, 0, 0, 0, 0, 0), "R8 pulses last one cycle");
    step(1, 8'hA0, EV_NONE, 1, 0, mk(8'h80, 0, 1, 0, 0, 0), "R8 cancel while receiving");
    step(1, 8'hC0, EV_NONE, 0, 0, mk(8'h80, 1, 0, 0, 1, 0), "R5 standby releases lines");
    step(1, 8'h00, EV_NONE, 0, 0, mk(8'h00, 0, 0, 0, 0, 1), "R10 disable clears standby");
    step(1, 8'hA0, EV_NONE, 1, 1, mk(8'h80, 0, 0, 0, 0, 0), "R3 cancel with enabling write");
    step(0, 8'h00, EV_NONE, 0, 0, mk(8'h80, 0, 0, 0, 0, 0), "R2 idle after enable");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChk++;
      nErr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end
endmodule